// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps wall-clock time and a calendar for a chip that already has a one-pulse-per-second tick. It counts seconds, minutes, hours, day of week, date, month and a two-digit year, and holds every field in packed BCD. The hours run in either 24-hour form or 12-hour form with an afternoon flag. February length follows the year, so leap years come out right across the full 00 to 99 range.

Software talks to it over a small byte-wide write port and a snapshot read path. Time writes go into a staging copy and reach the running counters only on a commit, all seven fields at once. Reads take a snapshot of all fields in one clock, so a rollover never shows half-updated. An alarm compares the running time against programmed second, minute, hour and date values. A periodic source fires on every tick, every minute, every hour or every day. Both sources set sticky status flags that are merged onto one interrupt line.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Each accepted tick advances the seconds by one in BCD 00..59. A wrap from 59 to 00 advances the minutes, which count 00..59 the same way.
- R2: With `mode_12h_i` low, hours count BCD 00..23. A wrap from 23:59:59 gives 00:00:00 and advances the day.
- R3: With `mode_12h_i` high, the hour byte holds BCD 01..12 in bits 4:0 and the afternoon flag in bit 7. The sequence is 12, 01 .. 11. The flag toggles on 11:59:59 to 12:00:00, and the day advances only when the flag goes from set to clear.
- R4: On each day advance, the day of week counts 1..7 and wraps from 7 to 1.
- R5: Dates run to 30 in months 04, 06, 09 and 11, to 31 in the other months, and to 28 in month 02. Month 02 runs to 29 when the year value is divisible by 4, including 00. After the last date comes date 01 of the next month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: Writes to addresses 0..6 (second, minute, hour, day of week, date, month, year) only fill a staging copy and leave the running time alone. A write to address 7 loads all seven staged fields in one clock. A tick in the same cycle as that load is dropped.
- R7: A pulse on `snap_i` copies all seven running fields into the `snap_*` outputs in one clock. The outputs then hold, whatever the counters do, until the next pulse.
- R8: Addresses 8..11 hold the alarm second, minute, hour and date. The control byte at address 12 has the alarm enable at bit 3. When enabled, a tick that makes all four running fields equal the alarm values sets `status_o[0]`. No flag is set when the alarm is disabled or any field differs.
- R9: Control bits 2:0 choose the periodic source: 0 none, 1 every tick, 2 each seconds wrap to 00, 3 each minute wrap at xx:59:59, 4 each day advance. A selected event sets `status_o[1]`.
- R10: Both flags are set on the clock edge after the one that applies the tick. They stay set until a write to address 13 with bit 0 (alarm) or bit 1 (periodic) set. A set in the same cycle as a clear wins, and `irq_o` is high while either flag is set.
- R11: After reset the time is 00:00:00, day of week 1, date 01, month 01, year 00. The snapshot shows those values, and both flags and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_12h_i | input | 1 | 1 selects 12-hour form with afternoon flag |
| tick_i | input | 1 | One-cycle pulse, one per second |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| snap_i | input | 1 | Capture the running time into the snapshot |
| snap_sec_o | output | 8 | Snapshot seconds, BCD |
| snap_min_o | output | 8 | Snapshot minutes, BCD |
| snap_hour_o | output | 8 | Snapshot hour byte |
| snap_dow_o | output | 8 | Snapshot day of week |
| snap_date_o | output | 8 | Snapshot date, BCD |
| snap_mon_o | output | 8 | Snapshot month, BCD |
| snap_year_o | output | 8 | Snapshot year, BCD |
| status_o | output | 2 | Bit 0 alarm flag, bit 1 periodic flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The counting chain is swept tick by tick for just over an hour in each hour form. One start sits at 22:59:58 on 31 December of year 99 with day of week 7, so a single run separates correct second, minute, hour, weekday, date, month and year carries from carries that fire a tick early or late. Month ends are tried for every month of all hundred years, and the 28th of February for each year, which tells leap from common years including year 00. Alarm, periodic and flag handling are probed with near-miss times, each periodic selection over the same 150-tick window, and a clear that lands on a set. The staging and snapshot paths are checked against ticks that arrive with no commit or snapshot, or in the same cycle as one.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int FW = 8;

   localparam int ADR_SEC    = 0;
   localparam int ADR_MIN    = 1;
   localparam int ADR_HOUR   = 2;
   localparam int ADR_DOW    = 3;
   localparam int ADR_DATE   = 4;
   localparam int ADR_MON    = 5;
   localparam int ADR_YEAR   = 6;
   localparam int ADR_COMMIT = 7;
   localparam int ADR_ALM0   = 8;
   localparam int ADR_CTRL   = 12;
   localparam int ADR_ACK    = 13;

   localparam int PER_OFF  = 0;
   localparam int PER_TICK = 1;
   localparam int PER_MIN  = 2;
   localparam int PER_HOUR = 3;
   localparam int PER_DAY  = 4;

   typedef struct packed {
      logic [FW-1:0] yr;
      logic [FW-1:0] mon;
      logic [FW-1:0] date;
      logic [FW-1:0] dow;
      logic [FW-1:0] hr;
      logic [FW-1:0] mnt;
      logic [FW-1:0] sec;
   } cal_t;

   function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [FW-1:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic logic leap_year(input logic [FW-1:0] yr);
      logic [6:0] b;
      b = bcd_to_bin(yr);
      return (b[1:0] == 2'b00);
   endfunction

   function automatic logic [FW-1:0] last_date(input logic [FW-1:0] mon,
                                               input logic [FW-1:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic cal_t cal_reset(input logic h12);
      cal_t c;
      c.yr   = 8'h00;
      c.mon  = 8'h01;
      c.date = 8'h01;
      c.dow  = 8'h01;
      c.hr   = h12 ? 8'h12 : 8'h00;
      c.mnt  = 8'h00;
      c.sec  = 8'h00;
      return c;
   endfunction

endpackage

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int PSEL_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_12h_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [FW-1:0]     wr_data_i,
   output cal_t              stage_o,
   output logic [3:0][FW-1:0] alarm_o,
   output logic              alarm_en_o,
   output logic [PSEL_W-1:0] psel_o,
   output logic              commit_o,
   output logic [1:0]        ack_o
);

   localparam int CTRL_W = PSEL_W + 1;

   cal_t              stage_q;
   logic [3:0][FW-1:0] alarm_q;
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q <= cal_reset(mode_12h_i);
         alarm_q <= '0;
         ctrl_q  <= '0;
      end else if (wr_en_i) begin
         case (int'(wr_addr_i))
            ADR_SEC:      stage_q.sec  <= wr_data_i;
            ADR_MIN:      stage_q.mnt  <= wr_data_i;
            ADR_HOUR:     stage_q.hr   <= wr_data_i;
            ADR_DOW:      stage_q.dow  <= wr_data_i;
            ADR_DATE:     stage_q.date <= wr_data_i;
            ADR_MON:      stage_q.mon  <= wr_data_i;
            ADR_YEAR:     stage_q.yr   <= wr_data_i;
            ADR_ALM0:     alarm_q[0]   <= wr_data_i;
            ADR_ALM0 + 1: alarm_q[1]   <= wr_data_i;
            ADR_ALM0 + 2: alarm_q[2]   <= wr_data_i;
            ADR_ALM0 + 3: alarm_q[3]   <= wr_data_i;
            ADR_CTRL:     ctrl_q       <= wr_data_i[CTRL_W-1:0];
            default: ;
         endcase
      end
   end

   assign commit_o   = wr_en_i && (int'(wr_addr_i) == ADR_COMMIT);
   assign ack_o      = (wr_en_i && (int'(wr_addr_i) == ADR_ACK)) ? wr_data_i[1:0] : 2'b00;
   assign stage_o    = stage_q;
   assign alarm_o    = alarm_q;
   assign alarm_en_o = ctrl_q[PSEL_W];
   assign psel_o     = ctrl_q[PSEL_W-1:0];

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_cal_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mode_12h_i,
   input  logic tick_i,
   input  logic load_i,
   input  cal_t load_val_i,
   output cal_t now_o,
   output logic step_o,
   output logic min_edge_o,
   output logic hour_edge_o,
   output logic day_edge_o
);

   cal_t          cur_q, nxt;
   logic          sec_end, min_end, hr_end, day_end, date_end, mon_end;
   logic [FW-1:0] hnum;

   always_comb begin
      nxt      = cur_q;
      hnum     = {3'b000, cur_q.hr[4:0]};
      sec_end  = (cur_q.sec == 8'h59);
      min_end  = sec_end && (cur_q.mnt == 8'h59);
      hr_end   = mode_12h_i ? (cur_q.hr[7] && hnum == 8'h11) : (cur_q.hr == 8'h23);
      day_end  = min_end && hr_end;
      date_end = (cur_q.date == last_date(cur_q.mon, cur_q.yr));
      mon_end  = date_end && (cur_q.mon == 8'h12);

      nxt.sec = sec_end ? 8'h00 : bcd_inc(cur_q.sec);
      if (sec_end)
         nxt.mnt = (cur_q.mnt == 8'h59) ? 8'h00 : bcd_inc(cur_q.mnt);
      if (min_end) begin
         if (!mode_12h_i)         nxt.hr = hr_end ? 8'h00 : bcd_inc(cur_q.hr);
         else if (hnum == 8'h12)  nxt.hr = {cur_q.hr[7], 7'h01};
         else if (hnum == 8'h11)  nxt.hr = {~cur_q.hr[7], 7'h12};
         else                     nxt.hr = {cur_q.hr[7], bcd_inc(hnum)[6:0]};
      end
      if (day_end) begin
         nxt.dow  = (cur_q.dow == 8'h07) ? 8'h01 : cur_q.dow + 8'h01;
         nxt.date = date_end ? 8'h01 : bcd_inc(cur_q.date);
         if (date_end)
            nxt.mon = (cur_q.mon == 8'h12) ? 8'h01 : bcd_inc(cur_q.mon);
         if (mon_end)
            nxt.yr = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q       <= cal_reset(mode_12h_i);
         step_o      <= 1'b0;
         min_edge_o  <= 1'b0;
         hour_edge_o <= 1'b0;
         day_edge_o  <= 1'b0;
      end else if (load_i) begin
         cur_q       <= load_val_i;
         step_o      <= 1'b0;
         min_edge_o  <= 1'b0;
         hour_edge_o <= 1'b0;
         day_edge_o  <= 1'b0;
      end else begin
         if (tick_i) cur_q <= nxt;
         step_o      <= tick_i;
         min_edge_o  <= tick_i && sec_end;
         hour_edge_o <= tick_i && min_end;
         day_edge_o  <= tick_i && day_end;
      end
   end

   assign now_o = cur_q;

endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
   import rtc_cal_pkg::*;
#(
   parameter int PSEL_W       = 3,
   parameter int ALARM_FIELDS = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               step_i,
   input  logic               min_edge_i,
   input  logic               hour_edge_i,
   input  logic               day_edge_i,
   input  logic [3:0][FW-1:0] now_f_i,
   input  logic [3:0][FW-1:0] alarm_i,
   input  logic               alarm_en_i,
   input  logic [PSEL_W-1:0]  psel_i,
   input  logic [1:0]         ack_i,
   output logic [1:0]         flags_o
);

   logic [3:0] match;
   logic       alarm_hit, per_hit;
   logic [1:0] flags_q;

   for (genvar g = 0; g < 4; g++) begin : g_cmp
      if (g < ALARM_FIELDS) begin : g_use
         assign match[g] = (now_f_i[g] == alarm_i[g]);
      end else begin : g_skip
         assign match[g] = 1'b1;
      end
   end

   assign alarm_hit = step_i && alarm_en_i && (&match);

   always_comb begin
      case (int'(psel_i))
         PER_TICK: per_hit = step_i;
         PER_MIN:  per_hit = min_edge_i;
         PER_HOUR: per_hit = hour_edge_i;
         PER_DAY:  per_hit = day_edge_i;
         default:  per_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= 2'b00;
      else         flags_q <= (flags_q & ~ack_i) | {per_hit, alarm_hit};
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int PSEL_W       = 3,
   parameter int ALARM_FIELDS = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_12h_i,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              snap_i,
   output logic [7:0]        snap_sec_o,
   output logic [7:0]        snap_min_o,
   output logic [7:0]        snap_hour_o,
   output logic [7:0]        snap_dow_o,
   output logic [7:0]        snap_date_o,
   output logic [7:0]        snap_mon_o,
   output logic [7:0]        snap_year_o,
   output logic [1:0]        status_o,
   output logic              irq_o
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover address 13");
   end
   if (PSEL_W < 3 || PSEL_W > 7) begin : g_bad_psel
      $error("PSEL_W must be 3..7");
   end
   if (ALARM_FIELDS < 1 || ALARM_FIELDS > 4) begin : g_bad_alm
      $error("ALARM_FIELDS must be 1..4");
   end

   cal_t               stage, now, snap_q;
   logic [3:0][FW-1:0] alarm, now_f;
   logic               alm_en, commit, step, min_edge, hour_edge, day_edge;
   logic [PSEL_W-1:0]  psel;
   logic [1:0]         ack, flags;

   rtc_reg_port #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_12h_i (mode_12h_i),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .stage_o    (stage),
      .alarm_o    (alarm),
      .alarm_en_o (alm_en),
      .psel_o     (psel),
      .commit_o   (commit),
      .ack_o      (ack)
   );

   rtc_time_core u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_12h_i  (mode_12h_i),
      .tick_i      (tick_i),
      .load_i      (commit),
      .load_val_i  (stage),
      .now_o       (now),
      .step_o      (step),
      .min_edge_o  (min_edge),
      .hour_edge_o (hour_edge),
      .day_edge_o  (day_edge)
   );

   assign now_f = {now.date, now.hr, now.mnt, now.sec};

   rtc_event_unit #(.PSEL_W(PSEL_W), .ALARM_FIELDS(ALARM_FIELDS)) u_evt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .step_i      (step),
      .min_edge_i  (min_edge),
      .hour_edge_i (hour_edge),
      .day_edge_i  (day_edge),
      .now_f_i     (now_f),
      .alarm_i     (alarm),
      .alarm_en_i  (alm_en),
      .psel_i      (psel),
      .ack_i       (ack),
      .flags_o     (flags)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     snap_q <= cal_reset(mode_12h_i);
      else if (snap_i) snap_q <= now;
   end

   assign snap_sec_o  = snap_q.sec;
   assign snap_min_o  = snap_q.mnt;
   assign snap_hour_o = snap_q.hr;
   assign snap_dow_o  = snap_q.dow;
   assign snap_date_o = snap_q.date;
   assign snap_mon_o  = snap_q.mon;
   assign snap_year_o = snap_q.yr;
   assign status_o    = flags;
   assign irq_o       = |flags;

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic              snap_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [7:0]        wr_data_i,
   input cal_t              snap_q,
   input logic [1:0]        status_o,
   input logic              alarm_en
);

   logic ack_alm, ack_per;
   assign ack_alm = wr_en_i && (int'(wr_addr_i) == ADR_ACK) && wr_data_i[0];
   assign ack_per = wr_en_i && (int'(wr_addr_i) == ADR_ACK) && wr_data_i[1];

   p_sec_bcd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snap_q.sec[3:0] <= 4'd9) && (snap_q.sec <= 8'h59));

   p_dow_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snap_q.dow >= 8'h01) && (snap_q.dow <= 8'h07));

   p_date_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snap_q.date >= 8'h01) && (snap_q.date <= 8'h31) &&
      (snap_q.mon >= 8'h01) && (snap_q.mon <= 8'h12));

   p_snap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(snap_i) |-> $stable(snap_q));

   p_alarm_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[0]) |-> ($past(alarm_en) && $past(tick_i, 2)));

   p_per_after_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[1]) |-> $past(tick_i, 2));

   p_alarm_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[0]) |-> $past(ack_alm));

   p_per_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[1]) |-> $past(ack_per));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tick_i    (tick_i),
   .snap_i    (snap_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .wr_data_i (wr_data_i),
   .snap_q    (snap_q),
   .status_o  (status_o),
   .alarm_en  (alm_en)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       mode_12h_i = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [3:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       snap_i = 1'b0;
   logic [7:0] snap_sec_o, snap_min_o, snap_hour_o, snap_dow_o;
   logic [7:0] snap_date_o, snap_mon_o, snap_year_o;
   logic [1:0] status_o;
   logic       irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   int ms, mm, mh, mdow, md, mmo, my;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   rtc_bcd_calendar dut_i (
      .clk_i, .rst_ni, .mode_12h_i, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
      .snap_i, .snap_sec_o, .snap_min_o, .snap_hour_o, .snap_dow_o,
      .snap_date_o, .snap_mon_o, .snap_year_o, .status_o, .irq_o
   );

   function automatic logic [7:0] bcd(input int x);
      return 8'(((x / 10) << 4) + (x % 10));
   endfunction

   function automatic int dim(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] ehour();
      int h12;
      if (!mode_12h_i) return bcd(mh);
      h12 = (mh % 12 == 0) ? 12 : mh % 12;
      return bcd(h12) | ((mh >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic logic [55:0] exp_time();
      return {bcd(my), bcd(mmo), bcd(md), bcd(mdow), ehour(), bcd(mm), bcd(ms)};
   endfunction

   function automatic logic [55:0] act_time();
      return {snap_year_o, snap_mon_o, snap_date_o, snap_dow_o, snap_hour_o,
              snap_min_o, snap_sec_o};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic mstep();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mdow = (mdow == 7) ? 1 : mdow + 1;
               md++;
               if (md > dim(mmo, my)) begin
                  md = 1; mmo++;
                  if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic tick();
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      @(negedge clk_i);
   endtask

   task automatic snap();
      snap_i = 1'b1;
      @(negedge clk_i);
      snap_i = 1'b0;
   endtask

   task automatic set_time(input int h, input int m, input int s, input int dw,
                           input int d, input int mo, input int y);
      mh = h; mm = m; ms = s; mdow = dw; md = d; mmo = mo; my = y;
      wr(0, bcd(s)); wr(1, bcd(m)); wr(2, ehour()); wr(3, bcd(dw));
      wr(4, bcd(d)); wr(5, bcd(mo)); wr(6, bcd(y)); wr(7, 8'h00);
   endtask

   task automatic check_time(input string req);
      snap();
      chk(act_time() == exp_time(), req, 64'(act_time()), 64'(exp_time()));
   endtask

   task automatic sweep(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick(); mstep(); check_time(req);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cnt;
      int exp_cnt [5];
      exp_cnt = '{0, 150, 3, 1, 1};

      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R11 reset state, before and after a snapshot
      mh = 0; mm = 0; ms = 0; mdow = 1; md = 1; mmo = 1; my = 0;
      chk(act_time() == exp_time(), "R11 snapshot", 64'(act_time()), 64'(exp_time()));
      chk(status_o == 2'b00 && irq_o == 1'b0, "R11 flags", {status_o, irq_o}, 0);
      check_time("R11 live");

      // R1 R2 R4 R5: 24-hour sweep over a full carry chain
      set_time(22, 59, 58, 7, 31, 12, 99);
      check_time("R6 commit");
      sweep(3610, "R1/R2/R4/R5 sweep24");

      // R3: 12-hour sweeps across noon and midnight
      mode_12h_i = 1'b1;
      set_time(10, 59, 58, 3, 14, 6, 21);
      sweep(3610, "R3 noon");
      set_time(22, 59, 58, 3, 14, 6, 21);
      sweep(3610, "R3 midnight");
      mode_12h_i = 1'b0;

      // R5: month ends of all years, and 28 February of each year
      for (int y = 0; y < 100; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_time(23, 59, 59, ((y + mo) % 7) + 1, dim(mo, y), mo, y);
            tick(); mstep(); check_time("R5 month end");
         end
         set_time(23, 59, 59, 7, 28, 2, y);
         tick(); mstep(); check_time("R5 feb 28");
      end

      // R6 staging and commit
      set_time(1, 2, 3, 2, 10, 3, 5);
      wr(0, 8'h30);
      tick(); mstep(); check_time("R6 staged write ignored");
      wr(7, 8'h00); ms = 30;
      check_time("R6 commit loads stage");
      wr(0, 8'h45);
      wr_en_i = 1'b1; wr_addr_i = 4'd7; wr_data_i = 8'h00; tick_i = 1'b1;
      @(negedge clk_i);
      wr_en_i = 1'b0; tick_i = 1'b0;
      @(negedge clk_i);
      ms = 45;
      check_time("R6 tick dropped on commit");

      // R7 snapshot holds
      for (int i = 0; i < 3; i++) begin tick(); mstep(); end
      chk(act_time() == {bcd(5), bcd(3), bcd(10), bcd(2), bcd(1), bcd(2), bcd(45)},
          "R7 snapshot holds", 64'(act_time()), 0);
      check_time("R7 snapshot refresh");

      // R8 alarm
      wr(13, 8'h03);
      set_time(5, 6, 7, 4, 15, 8, 40);
      wr(8, 8'h10); wr(9, 8'h06); wr(10, 8'h05); wr(11, 8'h15);
      wr(12, 8'h08);
      tick(); tick();
      chk(status_o[0] == 1'b0, "R8 early", status_o, 0);
      tick();
      chk(status_o[0] == 1'b1 && irq_o == 1'b1, "R8 alarm match", {status_o, irq_o}, 3'b011);
      wr(13, 8'h01);
      chk(status_o == 2'b00 && irq_o == 1'b0, "R10 alarm clear", {status_o, irq_o}, 0);
      set_time(5, 6, 9, 4, 16, 8, 40);
      tick();
      chk(status_o[0] == 1'b0, "R8 date differs", status_o, 0);
      set_time(5, 6, 9, 4, 15, 8, 40);
      wr(12, 8'h00);
      tick();
      chk(status_o[0] == 1'b0, "R8 disabled", status_o, 0);

      // R9 periodic selections over one window
      for (int sel = 0; sel < 5; sel++) begin
         set_time(23, 58, 30, 1, 1, 1, 0);
         wr(12, 8'(sel));
         wr(13, 8'h03);
         cnt = 0;
         for (int i = 0; i < 150; i++) begin
            tick();
            if (status_o[1]) cnt++;
            wr(13, 8'h02);
         end
         chk(cnt == exp_cnt[sel], "R9 periodic count", 64'(cnt), 64'(exp_cnt[sel]));
      end

      // R10 set wins over clear, flags are sticky
      wr(12, 8'h01);
      wr(13, 8'h03);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0; wr_en_i = 1'b1; wr_addr_i = 4'd13; wr_data_i = 8'h02;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      chk(status_o[1] == 1'b1, "R10 set wins", status_o, 2'b10);
      repeat (5) @(negedge clk_i);
      chk(status_o[1] == 1'b1 && irq_o == 1'b1, "R10 sticky", {status_o, irq_o}, 3'b101);
      wr(13, 8'h02);
      chk(status_o == 2'b00 && irq_o == 1'b0, "R10 clear", {status_o, irq_o}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule